// File: doc/BRIEF.md
# Programmable Interval Timer

A 16-bit down-counting timer that raises a periodic interrupt. Its tick source is the block clock divided by two and then by a power of two that software chooses, so one count step takes between 2 and 65536 clocks. Every time the count reaches zero, a sticky event flag is set. While the matching enable bit is also set, that flag drives a level interrupt line.

Software reaches the block through a small halfword-addressed register window. The window holds a control/status word, a modulus word and a read-only view of the live count. In reload mode the count restarts from the modulus after zero. In free-running mode it restarts from 0xFFFF. An overwrite option lets a modulus write load the count at once. The event flag is cleared by writing a one to it. A control write that toggles only the interrupt enable leaves the tick phase alone, so software can mask and unmask the interrupt without shifting the period.

Top module: `intv_timer`

## Requirements
- R1: After reset, offset 0 and offset 2 read 0x0000, offset 4 reads 0xFFFF, and `irq_o` is low.
- R2: Reads are decoded from the byte offset in `bus_addr`. Offset 0 selects the control word, offset 2 the modulus and offset 4 the live count. Offset 6, and any odd offset, read 0x0000. Writes to offsets 4 and 6, or to odd offsets, change no state.
- R3: The control word has these fields: bit 0 run, bit 1 reload, bit 2 event flag, bit 3 interrupt enable, bit 4 overwrite, bit 5 and bit 6 two stored-only bits, and bits 11:8 a divider exponent P. All other bits read 0. While run is 1, the count steps once every 2^(P+1) clocks. The first step lands exactly 2^(P+1) clocks after the write that restarts the divider.
- R4: A step from a nonzero count decrements it. A step from zero loads the modulus when reload is 1, and loads 0xFFFF when reload is 0.
- R5: The event flag becomes 1 on the step that makes the count equal zero.
- R6: A control write with bit 2 set clears the event flag. A control write with bit 2 clear leaves the flag as it was.
- R7: `irq_o` is 1 exactly when the event flag and the interrupt enable bit are both 1.
- R8: Every modulus write clears the event flag. When overwrite is 1, the same write also loads the count with the written value, in both reload and free-running modes. When overwrite is 0, the count is not changed.
- R9: A control write that differs from the stored word only in bits 2 and 3 keeps the divider phase. Any other change to the control word restarts the divider from zero.
- R10: While run is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of the count ticks |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe for writes |
| bus_wr | input | 1 | Write qualifier, used together with `bus_sel` |
| bus_addr | input | 3 | Byte offset into the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench follows the count cycle by cycle across reload and free-running wraps. A design that wrapped to the wrong value, or set the flag one step late, shows up as a trace mismatch. With a large exponent, the bench checks the exact clock of each step. It then issues one interrupt-enable-only write and one write that changes a real setting. A divider that restarted on the benign write, or missed the restart on the other one, moves a step off its expected cycle. The bench also checks the write-one-to-clear rule against a write-zero, flag clearing on a modulus write, immediate loading under overwrite in both modes, and writes to the read-only and unmapped offsets.

// File: rtl/intv_timer_pkg.sv
// Package: shared field positions and register selection for the interval timer.
// Assumes a 16-bit register window at byte offsets 0, 2 and 4.
package intv_timer_pkg;

    localparam int CB_RUN    = 0;
    localparam int CB_RELOAD = 1;
    localparam int CB_FLAG   = 2;
    localparam int CB_IEN    = 3;
    localparam int CB_OVW    = 4;
    localparam int CB_HOLD_A = 5;
    localparam int CB_HOLD_B = 6;
    localparam int CB_EXP_LO = 8;

    // Writable control bits, excluding the event flag, which is kept separately.
    localparam logic [15:0] CTRL_STORE_MASK = 16'h0F7B;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MOD  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Maps a byte offset to a register; odd offsets select nothing.
    function automatic reg_sel_e decode_sel(input logic [2:0] offs);
        if (offs[0]) begin
            return SEL_NONE;
        end
        unique case (offs[2:1])
            2'd0:    return SEL_CTRL;
            2'd1:    return SEL_MOD;
            2'd2:    return SEL_CNT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/intv_prescaler.sv
// Divider: emits a one-clock tick every 2^(exp+1) clocks while run is high.
// Assumes exp_i and run_i change only together with restart_i. The phase is
// held at zero while stopped, so the first tick after a restart arrives after
// one full period.
module intv_prescaler #(
    parameter int EXP_W = 4,
    localparam int PH_W = 1 << EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);

    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  ph_last;
    logic [EXP_W-1:0] shamt;

    // Terminal phase: 2^(exp+1) - 1.
    always_comb begin
        shamt   = EXP_W'(PH_W - 1) - exp_i;
        ph_last = {PH_W{1'b1}} >> shamt;
    end

    assign tick_o = run_i && (ph_q == ph_last);

    // Phase counter: cleared on restart, on stop and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (restart_i || !run_i || tick_o) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
        end
    end

    AST_PHASE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (ph_q == '0)); // R3
    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (ph_q <= ph_last)); // R3
    AST_STOPPED_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (ph_q == '0)); // R10

endmodule

// File: rtl/intv_counter.sv
// Down counter: steps on a tick, wraps to wrap_val_i after zero, and takes
// an immediate load with priority over a step. Reports when a step lands on
// zero.
module intv_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] wrap_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_hit_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_step;

    // Value the next step would produce.
    always_comb begin
        cnt_step = (cnt_q == '0) ? wrap_val_i : (cnt_q - CNT_W'(1));
    end

    assign zero_hit_o = tick_i && !load_i && (cnt_step == '0);
    assign cnt_o      = cnt_q;

    // Count register: reset to all ones, load beats step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i) begin
            cnt_q <= cnt_step;
        end
    end

    AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
    AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cnt_q == '0) |=> (cnt_q == $past(wrap_val_i))); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q)); // R10
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i))); // R8

endmodule

// File: rtl/intv_regs.sv
// Register file: control word, modulus and event flag, plus read mux and
// interrupt level. Decides when the divider restarts and when a modulus
// write loads the count. A set of the flag by the counter wins over a
// clear in the same cycle.
module intv_regs
    import intv_timer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              zero_hit_i,
    output logic              run_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              restart_o,
    output logic              load_o,
    output logic [DATA_W-1:0] wrap_val_o,
    output logic              irq_o
);

    reg_sel_e          sel;
    logic              ctrl_wr;
    logic              mod_wr;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] mod_q;
    logic              flag_q;
    logic [DATA_W-1:0] ctrl_new;
    logic              cfg_change;

    // Access decode and detection of a real configuration change.
    always_comb begin
        sel        = decode_sel(bus_addr);
        ctrl_wr    = bus_sel && bus_wr && (sel == SEL_CTRL);
        mod_wr     = bus_sel && bus_wr && (sel == SEL_MOD);
        ctrl_new   = bus_wdata & CTRL_STORE_MASK;
        cfg_change = (((ctrl_q ^ ctrl_new) & ~(DATA_W'(1) << CB_IEN)) != '0);
    end

    // Control word storage (flag excluded).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_new;
        end
    end

    // Modulus storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else if (mod_wr) begin
            mod_q <= bus_wdata;
        end
    end

    // Sticky event flag: set by the counter, cleared by write-one or a modulus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (zero_hit_i) begin
            flag_q <= 1'b1;
        end else if ((ctrl_wr && bus_wdata[CB_FLAG]) || mod_wr) begin
            flag_q <= 1'b0;
        end
    end

    // Control outputs to divider and counter.
    always_comb begin
        run_o      = ctrl_q[CB_RUN];
        exp_o      = ctrl_q[CB_EXP_LO +: EXP_W];
        load_o     = mod_wr && ctrl_q[CB_OVW];
        restart_o  = (ctrl_wr && cfg_change) || load_o;
        wrap_val_o = ctrl_q[CB_RELOAD] ? mod_q : '1;
        irq_o      = flag_q && ctrl_q[CB_IEN];
    end

    // Read mux by offset.
    always_comb begin
        unique case (sel)
            SEL_CTRL: bus_rdata = ctrl_q | (DATA_W'(flag_q) << CB_FLAG);
            SEL_MOD:  bus_rdata = mod_q;
            SEL_CNT:  bus_rdata = cnt_i;
            default:  bus_rdata = '0;
        endcase
    end

    AST_FLAG_ONLY_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(zero_hit_i)); // R5
    AST_ZERO_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit_i |=> flag_q); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CB_FLAG] && !zero_hit_i) |=> !flag_q); // R6
    AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && ctrl_wr && !bus_wdata[CB_FLAG]) |=> flag_q); // R6
    AST_MOD_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_wr && !zero_hit_i) |=> !flag_q); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bus_sel || !bus_sel) && flag_q && ctrl_q[CB_IEN]); // R7

endmodule

// File: rtl/intv_timer.sv
// Top: interval timer with a divider, a down counter and a register file.
// Assumes writes are single-cycle strobes on bus_sel && bus_wr; reads are
// combinational from bus_addr.
module intv_timer #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    logic              run;
    logic [EXP_W-1:0]  exp_sel;
    logic              restart;
    logic              load;
    logic [DATA_W-1:0] wrap_val;
    logic              tick;
    logic [DATA_W-1:0] cnt;
    logic              zero_hit;

    intv_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .EXP_W  (EXP_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_i      (cnt),
        .zero_hit_i (zero_hit),
        .run_o      (run),
        .exp_o      (exp_sel),
        .restart_o  (restart),
        .load_o     (load),
        .wrap_val_o (wrap_val),
        .irq_o      (irq_o)
    );

    intv_prescaler #(
        .EXP_W (EXP_W)
    ) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .exp_i     (exp_sel),
        .tick_o    (tick)
    );

    intv_counter #(
        .CNT_W (DATA_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (bus_wdata),
        .wrap_val_i (wrap_val),
        .cnt_o      (cnt),
        .zero_hit_o (zero_hit)
    );

    AST_COUNT_OFFSET_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(4) && !run) |=> $stable(cnt)); // R2
    AST_NO_TICK_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R10

endmodule

// File: tb/intv_timer_tb_top.sv
`timescale 1ns/100ps
module intv_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] exp;
        bit          is_irq;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2.5 clk = ~clk;

    intv_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Monitor: pops every queued expectation at the falling edge and compares.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {15'd0, irq_o} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    // Driver: single-cycle register write.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    // Driver: expect a read value for the current state, then advance one clock.
    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        bus_addr = a;
        sb_q.push_back('{tag, e, 1'b0});
        @(posedge clk);
        #1;
    endtask

    // Driver: expect an interrupt level for the current state (no advance).
    task automatic irq_exp(input logic e, input string tag);
        sb_q.push_back('{tag, {15'd0, e}, 1'b1});
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        irq_exp(1'b0, "R1 irq after reset");
        rd(3'd0, 16'h0000, "R1 ctrl after reset");
        rd(3'd2, 16'h0000, "R1 modulus after reset");
        rd(3'd4, 16'hFFFF, "R1 count after reset");

        // R8 modulus write without overwrite leaves the count
        wr(3'd2, 16'h0005);
        rd(3'd2, 16'h0005, "R8 modulus stored");
        rd(3'd4, 16'hFFFF, "R8 no overwrite keeps count");

        // R8 overwrite loads the count while stopped
        wr(3'd0, 16'h0012);
        wr(3'd2, 16'h0003);
        rd(3'd4, 16'h0003, "R8 overwrite load in reload mode");

        // R2 read-only and unmapped offsets
        wr(3'd4, 16'h1234);
        rd(3'd4, 16'h0003, "R2 write to count offset ignored");
        wr(3'd6, 16'hFFFF);
        rd(3'd6, 16'h0000, "R2 offset 6 reads zero");
        wr(3'd1, 16'hFFFF);
        rd(3'd0, 16'h0012, "R2 odd offset write ignored");
        rd(3'd1, 16'h0000, "R2 odd offset reads zero");

        // R3 R4 R5 reload trace, exponent 0 (step every 2 clocks)
        wr(3'd0, 16'h0013);
        for (int k = 0; k < 10; k++) begin
            logic [15:0] e;
            e = 16'((3 - (k / 2)) & 3);
            rd(3'd4, e, $sformatf("R4 reload trace k=%0d", k));
        end
        irq_exp(1'b0, "R7 flag without enable keeps irq low");
        rd(3'd0, 16'h0017, "R5 flag set after reaching zero");

        // R10 stop holds the count; R6 write-zero keeps flag
        wr(3'd0, 16'h0012);
        rd(3'd4, 16'h0001, "R10 count frozen after stop");
        rd(3'd0, 16'h0016, "R6 write-zero keeps flag");
        rd(3'd4, 16'h0001, "R10 count still frozen");

        // R7 enable interrupt, R6 clear by write-one
        wr(3'd0, 16'h001A);
        irq_exp(1'b1, "R7 irq with flag and enable");
        rd(3'd0, 16'h001E, "R7 ctrl with enable and flag");
        wr(3'd0, 16'h001E);
        irq_exp(1'b0, "R6 irq low after write-one clear");
        rd(3'd0, 16'h001A, "R6 flag cleared by write-one");

        // R4 free-running wrap to 0xFFFF, R8 overwrite in free mode
        wr(3'd0, 16'h0010);
        wr(3'd2, 16'h0002);
        rd(3'd4, 16'h0002, "R8 overwrite load in free mode");
        wr(3'd0, 16'h0011);
        for (int k = 0; k < 9; k++) begin
            int s;
            logic [15:0] e;
            s = k / 2;
            e = (s <= 2) ? 16'(2 - s) : 16'(16'hFFFF - (s - 3));
            rd(3'd4, e, $sformatf("R4 free trace k=%0d", k));
        end
        wr(3'd0, 16'h0010);
        rd(3'd0, 16'h0014, "R5 flag set in free mode");
        wr(3'd2, 16'h0040);
        rd(3'd0, 16'h0010, "R8 modulus write clears flag");
        rd(3'd4, 16'h0040, "R8 overwrite count value");

        // R3 exponent 3: step every 16 clocks
        wr(3'd0, 16'h0311);
        for (int k = 0; k < 33; k++) begin
            rd(3'd4, 16'(16'h0040 - (k / 16)), $sformatf("R3 divide-by-16 k=%0d", k));
        end
        // R9 enable-only write keeps phase
        wr(3'd0, 16'h0319);
        for (int k = 34; k < 50; k++) begin
            rd(3'd4, 16'(16'h0040 - (k / 16)), $sformatf("R9 phase kept k=%0d", k));
        end
        // R9 real change restarts phase
        wr(3'd0, 16'h031B);
        irq_exp(1'b0, "R7 enable without flag keeps irq low");
        for (int k = 51; k < 68; k++) begin
            rd(3'd4, (k >= 67) ? 16'h003C : 16'h003D, $sformatf("R9 phase restart k=%0d", k));
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule